// File: doc/BRIEF.md
# AUX Channel Request Sequencer

This block turns a host's request for a native read, a native write or a single I2C-over-AUX byte into a message for a half-duplex AUX transaction engine. It assembles the four-byte request header and any payload into a flat message buffer and pulses a start strobe. When the engine reports back, the block reads its completion status and reply byte. It then decides whether to finish, retry at once, or wait out a defer interval before retrying. At the end it hands the host a signed result: a byte count on success, a negative error code otherwise.

The host side is a valid/ready request port. `req_ready` is high only while the block is idle, so a request is accepted only on a cycle where both `req_valid` and `req_ready` are high. From that cycle until the completion pulse, back-pressure holds: no second request is accepted. Completion is a single-cycle `done_valid` strobe carrying `done_result` and `done_data`, and there is no way to stall it. The defer interval is counted in pulses of the `tick` input, which comes from an external prescaler. The interval is `DEFER_TICKS` pulses long, 400 by default, which gives 400 µs with a 1 µs tick.

Top module: `aux_requester`

## Requirements
- R1: `req_ready` is high only in the idle state. An accepted request drops it on the next cycle. `eng_start` is a one-cycle pulse in the cycle after acceptance. `done_valid` is high for exactly one cycle per request.
- R2: Message byte 0 is address bits [7:0] and byte 1 is address bits [15:8]. Byte 2 holds a command in bits [7:4] and zero in bits [3:0]. The command codes are 8 for a native write, 9 for a native read, 0 for an I2C write and 1 for an I2C read. For I2C, 4 is added to the command when `req_i2c_stop` is low.
- R3: Byte 3 and `eng_msg_len` depend on the request kind.
  - Native write: byte 3 is ((len+4) mod 16)<<4 | (len-1), the length is len+4, and payload byte i sits at message byte 4+i.
  - Native read: byte 3 is 0x40 | (len-1) and the length is 4.
  - I2C write: byte 3 is 0x50, the length is 5, and the data byte is at byte 4.
  - I2C read: byte 3 is 0x40 and the length is 4.
  - I2C address-only: byte 3 is 0x30 and the length is 4.
  - Unused message bytes are zero.
- R4: A native write longer than 16 bytes completes with result -1 and never pulses `eng_start`.
- R5: Engine status 1 (timeout) ends the request at once with -110. Status 3 (fault) ends it at once with -5.
- R6: Engine status 2 (busy) pulses `eng_start` again in the cycle right after `eng_done`, with no defer wait.
- R7: The native reply field is reply bits [5:4]: 0 means ACK, 1 NACK, 2 DEFER and 3 invalid. After a DEFER the next `eng_start` comes in the cycle after the `DEFER_TICKS`-th tick pulse seen while waiting.
- R8: At most 4 attempts are made. If the 4th attempt ends busy or deferred, the result is -5 for native requests and -121 for I2C requests, with no further wait.
- R9: A native write ACK returns the payload length. A native write NACK or invalid reply returns -5.
- R10: A native read ACK returns min(`eng_rx_len`, len). A NACK or invalid reply returns -71 if that clamped count is zero, and -5 otherwise.
- R11: For I2C, a native NACK or invalid reply returns -121. The I2C field, reply bits [7:6], is examined only after a native ACK: 0 returns min(`eng_rx_len`, 1), 1 or 3 returns -121, and 2 waits like a defer. An acknowledged I2C read puts `eng_rx_byte` on `done_data`; every other result puts 0 there.
- R12: After reset, `req_ready` is high and `eng_start` and `done_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle, request can be accepted |
| req_kind | input | 2 | 0 native read, 1 native write, 2 or 3 I2C byte |
| req_addr | input | 16 | Target address |
| req_len | input | 5 | Payload or read length in bytes |
| req_i2c_read | input | 1 | I2C direction is read |
| req_i2c_stop | input | 1 | I2C transfer ends with a stop |
| req_i2c_addr_only | input | 1 | I2C transfer carries no data byte |
| req_wdata | input | 128 | Write payload, byte i at bits [8i+7:8i] |
| tick | input | 1 | Prescaled timebase pulse for the defer wait |
| eng_start | output | 1 | Start one engine transaction |
| eng_msg | output | 160 | Message buffer, byte i at bits [8i+7:8i] |
| eng_msg_len | output | 5 | Bytes of `eng_msg` to send |
| eng_done | input | 1 | Engine transaction finished |
| eng_status | input | 2 | 0 ok, 1 timeout, 2 busy, 3 fault |
| eng_reply | input | 8 | Reply code byte |
| eng_rx_len | input | 5 | Bytes received |
| eng_rx_byte | input | 8 | First received byte |
| done_valid | output | 1 | One-cycle completion strobe |
| done_result | output | 8 | Signed byte count or negative error |
| done_data | output | 8 | Received byte for an acknowledged I2C read |

## Verification
A bad attempt counter shows up at completion. The request either finishes after too few engine starts or sends a fifth start, so the bench counts starts for every scenario. A defer counter that is off by one moves the restart one tick earlier or later, and the bench measures this to the exact cycle. A mis-decoded reply or wrong clamp appears on `done_result` in the same cycle the strobe fires. Header faults appear on `eng_msg` at the first start, before any reply arrives.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;
  localparam int HDR_BYTES   = 4;
  localparam int MAX_PAYLOAD = 16;
  localparam int MSG_BYTES   = HDR_BYTES + MAX_PAYLOAD;
  localparam int LEN_W       = 5;
  localparam int MLEN_W      = $clog2(MSG_BYTES + 1);

  localparam logic [1:0] KIND_NRD = 2'd0;
  localparam logic [1:0] KIND_NWR = 2'd1;

  localparam logic [3:0] CMD_NWR    = 4'h8;
  localparam logic [3:0] CMD_NRD    = 4'h9;
  localparam logic [3:0] CMD_I2C_WR = 4'h0;
  localparam logic [3:0] CMD_I2C_RD = 4'h1;
  localparam logic [3:0] CMD_MOT    = 4'h4;

  localparam logic [1:0] ST_OK      = 2'd0;
  localparam logic [1:0] ST_TIMEOUT = 2'd1;
  localparam logic [1:0] ST_BUSY    = 2'd2;
  localparam logic [1:0] ST_FAULT   = 2'd3;

  localparam logic [1:0] RP_ACK   = 2'd0;
  localparam logic [1:0] RP_DEFER = 2'd2;

  typedef logic signed [7:0] result_t;
  localparam result_t RES_REJECT  = -8'sd1;
  localparam result_t RES_IO      = -8'sd5;
  localparam result_t RES_PROTO   = -8'sd71;
  localparam result_t RES_TIMEOUT = -8'sd110;
  localparam result_t RES_REMOTE  = -8'sd121;

  typedef enum logic [1:0] {ACT_FINISH, ACT_AGAIN, ACT_DEFER} act_e;
endpackage

// File: rtl/aux_hdr_build.sv
module aux_hdr_build
  import aux_req_pkg::*;
(
  input  logic [1:0]               kind,
  input  logic [15:0]              addr,
  input  logic [LEN_W-1:0]         len,
  input  logic                     i2c_read,
  input  logic                     i2c_stop,
  input  logic                     i2c_addr_only,
  input  logic [MAX_PAYLOAD*8-1:0] wdata,
  output logic [MSG_BYTES*8-1:0]   msg,
  output logic [MLEN_W-1:0]        msg_len
);
  logic                     is_i2c, is_wr;
  logic [3:0]               cmd;
  logic [7:0]               size_byte;
  logic [LEN_W-1:0]         len_m1;
  logic [LEN_W:0]           total;
  logic [MAX_PAYLOAD*8-1:0] pay_flat;

  always_comb begin
    is_i2c = kind[1];
    is_wr  = (kind == KIND_NWR);
    len_m1 = len - 1'b1;
    total  = {1'b0, len} + (LEN_W+1)'(HDR_BYTES);
    if (is_i2c) begin
      cmd = i2c_read ? CMD_I2C_RD : CMD_I2C_WR;
      if (!i2c_stop) cmd = cmd | CMD_MOT;
      if (i2c_addr_only) begin
        size_byte = 8'h30;
        msg_len   = MLEN_W'(HDR_BYTES);
      end else if (i2c_read) begin
        size_byte = 8'h40;
        msg_len   = MLEN_W'(HDR_BYTES);
      end else begin
        size_byte = 8'h50;
        msg_len   = MLEN_W'(HDR_BYTES + 1);
      end
    end else if (is_wr) begin
      cmd       = CMD_NWR;
      size_byte = {total[3:0], len_m1[3:0]};
      msg_len   = MLEN_W'(total);
    end else begin
      cmd       = CMD_NRD;
      size_byte = {4'h4, len_m1[3:0]};
      msg_len   = MLEN_W'(HDR_BYTES);
    end
  end

  for (genvar i = 0; i < MAX_PAYLOAD; i++) begin : g_pay
    localparam bit FIRST = (i == 0);
    logic en;
    assign en = (is_wr && (LEN_W'(i) < len)) ||
                (FIRST && is_i2c && !i2c_read && !i2c_addr_only);
    assign pay_flat[i*8 +: 8] = en ? wdata[i*8 +: 8] : 8'h00;
  end

  assign msg = {pay_flat, size_byte, cmd, 4'h0, addr};
endmodule

// File: rtl/aux_reply_decode.sv
module aux_reply_decode
  import aux_req_pkg::*;
(
  input  logic             is_i2c,
  input  logic             is_wr,
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       status,
  input  logic [7:0]       reply,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             last,
  output act_e             act,
  output result_t          result,
  output logic             take_byte
);
  logic [1:0]       nat, i2cf;
  logic [LEN_W-1:0] cap, clamped;
  logic             again, wait_more;

  always_comb begin
    nat       = reply[5:4];
    i2cf      = reply[7:6];
    cap       = is_i2c ? LEN_W'(1) : len;
    clamped   = (rx_len > cap) ? cap : rx_len;
    again     = 1'b0;
    wait_more = 1'b0;
    take_byte = 1'b0;
    result    = RES_IO;
    act       = ACT_FINISH;
    case (status)
      ST_TIMEOUT: result = RES_TIMEOUT;
      ST_FAULT:   result = RES_IO;
      ST_BUSY:    again  = 1'b1;
      default: begin
        if (!is_i2c) begin
          if (nat == RP_ACK)
            result = is_wr ? result_t'({3'b000, len}) : result_t'({3'b000, clamped});
          else if (nat == RP_DEFER)
            wait_more = 1'b1;
          else if (is_wr)
            result = RES_IO;
          else
            result = (clamped == '0) ? RES_PROTO : RES_IO;
        end else begin
          if (nat == RP_ACK) begin
            if (i2cf == RP_ACK) begin
              result    = result_t'({3'b000, clamped});
              take_byte = 1'b1;
            end else if (i2cf == RP_DEFER) begin
              wait_more = 1'b1;
            end else begin
              result = RES_REMOTE;
            end
          end else if (nat == RP_DEFER) begin
            wait_more = 1'b1;
          end else begin
            result = RES_REMOTE;
          end
        end
      end
    endcase
    if (again || wait_more) begin
      if (last) result = is_i2c ? RES_REMOTE : RES_IO;
      else      act    = again ? ACT_AGAIN : ACT_DEFER;
    end
  end
endmodule

// File: rtl/aux_defer_timer.sv
module aux_defer_timer #(
  parameter int TICKS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
  logic [CW-1:0] cnt;

  assign expire = run && tick && (cnt == CW'(TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/aux_requester.sv
module aux_requester
  import aux_req_pkg::*;
#(
  parameter int DEFER_TICKS = 400,
  parameter int MAX_TRIES   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [1:0]                    req_kind,
  input  logic [15:0]                   req_addr,
  input  logic [4:0]                    req_len,
  input  logic                          req_i2c_read,
  input  logic                          req_i2c_stop,
  input  logic                          req_i2c_addr_only,
  input  logic [127:0]                  req_wdata,
  input  logic                          tick,
  output logic                          eng_start,
  output logic [159:0]                  eng_msg,
  output logic [4:0]                    eng_msg_len,
  input  logic                          eng_done,
  input  logic [1:0]                    eng_status,
  input  logic [7:0]                    eng_reply,
  input  logic [4:0]                    eng_rx_len,
  input  logic [7:0]                    eng_rx_byte,
  output logic                          done_valid,
  output logic [7:0]                    done_result,
  output logic [7:0]                    done_data
);
  localparam int TW = $clog2(MAX_TRIES + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_WAIT_ENG, S_DEFER, S_RESP} state_e;

  state_e                   st;
  logic [1:0]               r_kind;
  logic [15:0]              r_addr;
  logic [LEN_W-1:0]         r_len;
  logic                     r_rd, r_stop, r_ao;
  logic [MAX_PAYLOAD*8-1:0] r_wdata;
  logic [TW-1:0]            tries;
  result_t                  r_res;
  logic [7:0]               r_data;

  logic    accept, too_long, last, expire, take_byte;
  act_e    act;
  result_t dec_res;

  assign req_ready   = (st == S_IDLE);
  assign eng_start   = (st == S_START);
  assign done_valid  = (st == S_RESP);
  assign done_result = r_res;
  assign done_data   = r_data;

  assign accept   = req_valid && req_ready;
  assign too_long = (req_kind == KIND_NWR) && (req_len > LEN_W'(MAX_PAYLOAD));
  assign last     = (tries == TW'(MAX_TRIES));

  aux_hdr_build u_hdr (
    .kind(r_kind), .addr(r_addr), .len(r_len), .i2c_read(r_rd),
    .i2c_stop(r_stop), .i2c_addr_only(r_ao), .wdata(r_wdata),
    .msg(eng_msg), .msg_len(eng_msg_len)
  );

  aux_reply_decode u_dec (
    .is_i2c(r_kind[1]), .is_wr(r_kind == KIND_NWR), .len(r_len),
    .status(eng_status), .reply(eng_reply), .rx_len(eng_rx_len),
    .last(last), .act(act), .result(dec_res), .take_byte(take_byte)
  );

  aux_defer_timer #(.TICKS(DEFER_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(st == S_DEFER), .tick(tick), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_kind  <= '0;
      r_addr  <= '0;
      r_len   <= '0;
      r_rd    <= 1'b0;
      r_stop  <= 1'b0;
      r_ao    <= 1'b0;
      r_wdata <= '0;
      tries   <= '0;
      r_res   <= '0;
      r_data  <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          r_kind  <= req_kind;
          r_addr  <= req_addr;
          r_len   <= req_len;
          r_rd    <= req_i2c_read;
          r_stop  <= req_i2c_stop;
          r_ao    <= req_i2c_addr_only;
          r_wdata <= req_wdata;
          tries   <= '0;
          r_data  <= '0;
          if (too_long) begin
            r_res <= RES_REJECT;
            st    <= S_RESP;
          end else begin
            st    <= S_START;
          end
        end
        S_START: begin
          tries <= tries + 1'b1;
          st    <= S_WAIT_ENG;
        end
        S_WAIT_ENG: if (eng_done) begin
          case (act)
            ACT_AGAIN: st <= S_START;
            ACT_DEFER: st <= S_DEFER;
            default: begin
              r_res  <= dec_res;
              r_data <= (take_byte && r_rd && !r_ao) ? eng_rx_byte : 8'h00;
              st     <= S_RESP;
            end
          endcase
        end
        S_DEFER: if (expire) st <= S_START;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R1
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R1
  AST_REJECT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && too_long) |=> (done_valid && !eng_start)); // R4
  AST_FAIL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT_ENG && eng_done && eng_status == ST_TIMEOUT) |=>
      (done_valid && done_result == RES_TIMEOUT)); // R5
  AST_BUSY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT_ENG && eng_done && eng_status == ST_BUSY && !last) |=> eng_start); // R6
  AST_DEFER_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEFER && !tick) |=> !eng_start); // R7
  AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TW'(MAX_TRIES)); // R8
endmodule

// File: tb/aux_requester_tb.sv
module aux_requester_tb_top;
  localparam int DEFER_N = 5;

  typedef struct packed {
    logic [1:0]        kind;
    logic [4:0]        len;
    logic              rd;
    logic [4:0]        rx;
    logic [7:0]        st;
    logic [31:0]       rp;
    logic signed [7:0] res;
    logic [2:0]        tries;
    logic [3:0]        req;
  } vec_t;

  // R5 R6 R7 R8 R9 R10 R11 scenarios; status/reply for attempt a at st[2a+:2], rp[8a+:8]
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'd4, 1'b0, 5'd4, 8'h00, 32'h00000000,   8'sd4, 3'd1, 4'd10},
    '{2'd0, 5'd2, 1'b0, 5'd5, 8'h00, 32'h00000000,   8'sd2, 3'd1, 4'd10},
    '{2'd0, 5'd3, 1'b0, 5'd0, 8'h00, 32'h00000010, -8'sd71, 3'd1, 4'd10},
    '{2'd0, 5'd3, 1'b0, 5'd2, 8'h00, 32'h00000010,  -8'sd5, 3'd1, 4'd10},
    '{2'd1, 5'd3, 1'b0, 5'd0, 8'h00, 32'h00000000,   8'sd3, 3'd1, 4'd9},
    '{2'd1, 5'd2, 1'b0, 5'd0, 8'h00, 32'h00000030,  -8'sd5, 3'd1, 4'd9},
    '{2'd0, 5'd2, 1'b0, 5'd0, 8'h01, 32'h00000000, -8'sd110, 3'd1, 4'd5},
    '{2'd1, 5'd2, 1'b0, 5'd0, 8'h03, 32'h00000000,  -8'sd5, 3'd1, 4'd5},
    '{2'd0, 5'd1, 1'b0, 5'd1, 8'h0A, 32'h00000000,   8'sd1, 3'd3, 4'd6},
    '{2'd0, 5'd1, 1'b0, 5'd1, 8'hAA, 32'h00000000,  -8'sd5, 3'd4, 4'd8},
    '{2'd2, 5'd1, 1'b1, 5'd1, 8'hAA, 32'h00000000, -8'sd121, 3'd4, 4'd8},
    '{2'd1, 5'd1, 1'b0, 5'd0, 8'h00, 32'h00002020,   8'sd1, 3'd3, 4'd7},
    '{2'd0, 5'd2, 1'b0, 5'd2, 8'h00, 32'h20202020,  -8'sd5, 3'd4, 4'd8},
    '{2'd2, 5'd1, 1'b1, 5'd1, 8'h00, 32'h00000080,   8'sd1, 3'd2, 4'd11},
    '{2'd2, 5'd1, 1'b1, 5'd1, 8'h00, 32'h00000010, -8'sd121, 3'd1, 4'd11},
    '{2'd2, 5'd1, 1'b1, 5'd1, 8'h00, 32'h00000040, -8'sd121, 3'd1, 4'd11},
    '{2'd2, 5'd1, 1'b1, 5'd1, 8'h00, 32'h000000B0, -8'sd121, 3'd1, 4'd11},
    '{2'd2, 5'd1, 1'b1, 5'd1, 8'h00, 32'h00000060,   8'sd1, 3'd2, 4'd11},
    '{2'd2, 5'd1, 1'b1, 5'd3, 8'h00, 32'h00000000,   8'sd1, 3'd1, 4'd11},
    '{2'd2, 5'd1, 1'b1, 5'd1, 8'h00, 32'h000000C0, -8'sd121, 3'd1, 4'd11}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [4:0] req_len = '0;
  logic req_i2c_read = 1'b0, req_i2c_stop = 1'b0, req_i2c_addr_only = 1'b0;
  logic [127:0] req_wdata = '0;
  logic tick = 1'b0;
  logic eng_start;
  logic [159:0] eng_msg;
  logic [4:0] eng_msg_len;
  logic eng_done = 1'b0;
  logic [1:0] eng_status = '0;
  logic [7:0] eng_reply = '0;
  logic [4:0] eng_rx_len = '0;
  logic [7:0] eng_rx_byte = '0;
  logic done_valid;
  logic [7:0] done_result;
  logic [7:0] done_data;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int tick_div = 0;
  logic [159:0] cap_msg;
  logic [4:0] cap_len;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tick_div <= (tick_div == 2) ? 0 : tick_div + 1;
    tick     <= (tick_div == 2);
  end

  aux_requester #(.DEFER_TICKS(DEFER_N), .MAX_TRIES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len),
    .req_i2c_read(req_i2c_read), .req_i2c_stop(req_i2c_stop),
    .req_i2c_addr_only(req_i2c_addr_only), .req_wdata(req_wdata), .tick(tick),
    .eng_start(eng_start), .eng_msg(eng_msg), .eng_msg_len(eng_msg_len),
    .eng_done(eng_done), .eng_status(eng_status), .eng_reply(eng_reply),
    .eng_rx_len(eng_rx_len), .eng_rx_byte(eng_rx_byte), .done_valid(done_valid),
    .done_result(done_result), .done_data(done_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic int gap_kind(input logic [1:0] kind, input logic [1:0] s, input logic [7:0] r);
    if (s == 2'd2) return 1;
    if (s != 2'd0) return 0;
    if (r[5:4] == 2'd2) return 2;
    if (kind[1] && r[5:4] == 2'd0 && r[7:6] == 2'd2) return 2;
    return 0;
  endfunction

  task automatic run_req(input logic [1:0] kind, input logic [15:0] addr, input logic [4:0] len,
                         input logic rd, input logic stop, input logic ao, input logic [127:0] wd,
                         input logic [7:0] stv, input logic [31:0] rpv, input logic [4:0] rx,
                         input logic [7:0] rxb, output int res, output int data, output int tries);
    int guard;
    bit got;
    @(negedge clk);
    req_kind = kind; req_addr = addr; req_len = len; req_i2c_read = rd;
    req_i2c_stop = stop; req_i2c_addr_only = ao; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 ready low after accept", req_ready, 0);
    tries = 0; got = 1'b0; guard = 0; res = 0; data = 0;
    while (!got && guard < 4000) begin
      guard++;
      if (eng_start) begin
        int gk;
        if (tries == 0) begin cap_msg = eng_msg; cap_len = eng_msg_len; end
        tries++;
        @(negedge clk);
        chk(eng_start == 1'b0, "R1 start one cycle", eng_start, 0);
        eng_done = 1'b1;
        eng_status = (tries <= 4) ? stv[2*(tries-1) +: 2] : 2'd0;
        eng_reply  = (tries <= 4) ? rpv[8*(tries-1) +: 8] : 8'h00;
        eng_rx_len = rx; eng_rx_byte = rxb;
        gk = gap_kind(kind, eng_status, eng_reply);
        @(negedge clk);
        eng_done = 1'b0;
        if (tries < 4 && gk == 1) begin
          chk(eng_start == 1'b1, "R6 busy restart next cycle", eng_start, 1);
        end else if (tries < 4 && gk == 2) begin
          int k, ticks, lastk;
          k = 0; ticks = 0; lastk = -1;
          while (!eng_start && k < 2000) begin
            if (tick) begin ticks++; lastk = k; end
            @(negedge clk);
            k++;
          end
          chk(ticks == DEFER_N, "R7 defer tick count", ticks, DEFER_N);
          chk(lastk == k - 1, "R7 restart right after last tick", lastk, k - 1);
        end
      end else if (done_valid) begin
        res = int'($signed(done_result));
        data = int'(done_data);
        got = 1'b1;
        @(negedge clk);
        chk(done_valid == 1'b0, "R1 done one cycle", done_valid, 0);
      end else begin
        @(negedge clk);
      end
    end
    if (!got) chk(1'b0, "R1 request never completed", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R1: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int res, data, tries;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(req_ready == 1'b1, "R12 ready after reset", req_ready, 1);
    chk(eng_start == 1'b0, "R12 no start after reset", eng_start, 0);
    chk(done_valid == 1'b0, "R12 no done after reset", done_valid, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      string tag;
      t = VECS[v];
      tag = $sformatf("R%0d vector %0d", t.req, v);
      run_req(t.kind, 16'h0100 + 16'(v), t.len, t.rd, 1'b1, 1'b0, 128'h0,
              t.st, t.rp, t.rx, 8'h3C, res, data, tries);
      chk(res == int'(t.res), {tag, " result"}, res, int'(t.res));
      chk(tries == int'(t.tries), {tag, " attempts"}, tries, int'(t.tries));
    end

    // R2 R3 R9 native write header and payload
    run_req(2'd1, 16'h1234, 5'd3, 1'b0, 1'b1, 1'b0, 128'h00CCBBAA,
            8'h00, 32'h0, 5'd0, 8'h00, res, data, tries);
    chk(cap_msg[7:0] == 8'h34, "R2 addr low", cap_msg[7:0], 8'h34);
    chk(cap_msg[15:8] == 8'h12, "R2 addr high", cap_msg[15:8], 8'h12);
    chk(cap_msg[23:16] == 8'h80, "R2 native write cmd", cap_msg[23:16], 8'h80);
    chk(cap_msg[31:24] == 8'h72, "R3 write size byte", cap_msg[31:24], 8'h72);
    chk(cap_msg[55:32] == 24'hCCBBAA, "R3 payload", cap_msg[55:32], 24'hCCBBAA);
    chk(cap_msg[159:56] == '0, "R3 unused zero", 0, 0);
    chk(cap_len == 5'd7, "R3 write length", cap_len, 7);
    chk(res == 3, "R9 write ack count", res, 3);

    // R2 R3 R10 native read of 16
    run_req(2'd0, 16'hABCD, 5'd16, 1'b0, 1'b1, 1'b0, 128'h0,
            8'h00, 32'h0, 5'd16, 8'h00, res, data, tries);
    chk(cap_msg[23:16] == 8'h90, "R2 native read cmd", cap_msg[23:16], 8'h90);
    chk(cap_msg[31:24] == 8'h4F, "R3 read size byte", cap_msg[31:24], 8'h4F);
    chk(cap_len == 5'd4, "R3 read length", cap_len, 4);
    chk(res == 16, "R10 read count", res, 16);

    // R3 native write of 16, nibble wraps
    run_req(2'd1, 16'h0002, 5'd16, 1'b0, 1'b1, 1'b0, {8'hF0, 120'h0},
            8'h00, 32'h0, 5'd0, 8'h00, res, data, tries);
    chk(cap_msg[31:24] == 8'h4F, "R3 write16 size byte", cap_msg[31:24], 8'h4F);
    chk(cap_len == 5'd20, "R3 write16 length", cap_len, 20);
    chk(cap_msg[159:152] == 8'hF0, "R3 write16 last payload", cap_msg[159:152], 8'hF0);

    // R2 R3 I2C write without stop
    run_req(2'd2, 16'h0050, 5'd1, 1'b0, 1'b0, 1'b0, 128'h5A,
            8'h00, 32'h0, 5'd0, 8'h00, res, data, tries);
    chk(cap_msg[23:16] == 8'h40, "R2 i2c write with MOT", cap_msg[23:16], 8'h40);
    chk(cap_msg[31:24] == 8'h50, "R3 i2c write size", cap_msg[31:24], 8'h50);
    chk(cap_msg[39:32] == 8'h5A, "R3 i2c data byte", cap_msg[39:32], 8'h5A);
    chk(cap_len == 5'd5, "R3 i2c write length", cap_len, 5);
    chk(res == 0 && data == 0, "R11 i2c write ack zero bytes", res, 0);

    // R2 R3 R11 I2C read with stop
    run_req(2'd2, 16'h0050, 5'd1, 1'b1, 1'b1, 1'b0, 128'h0,
            8'h00, 32'h0, 5'd1, 8'h77, res, data, tries);
    chk(cap_msg[23:16] == 8'h10, "R2 i2c read stop cmd", cap_msg[23:16], 8'h10);
    chk(cap_msg[31:24] == 8'h40, "R3 i2c read size", cap_msg[31:24], 8'h40);
    chk(cap_len == 5'd4, "R3 i2c read length", cap_len, 4);
    chk(data == 8'h77, "R11 i2c read data", data, 8'h77);

    // R3 I2C address-only
    run_req(2'd2, 16'h0050, 5'd1, 1'b0, 1'b0, 1'b1, 128'hEE,
            8'h00, 32'h0, 5'd0, 8'h00, res, data, tries);
    chk(cap_msg[31:24] == 8'h30, "R3 addr-only size", cap_msg[31:24], 8'h30);
    chk(cap_msg[39:32] == 8'h00, "R3 addr-only no data", cap_msg[39:32], 0);
    chk(cap_len == 5'd4, "R3 addr-only length", cap_len, 4);

    // R4 oversize write rejected
    run_req(2'd1, 16'h0000, 5'd17, 1'b0, 1'b1, 1'b0, 128'h0,
            8'h00, 32'h0, 5'd0, 8'h00, res, data, tries);
    chk(res == -1, "R4 reject code", res, -1);
    chk(tries == 0, "R4 no engine start", tries, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule